// File: doc/BRIEF.md
# Host Controller Boot Sequencer

This block sits in the glue logic next to a USB host controller and boots that controller through its host-port interface (HPI). Once per power cycle, after the first reset, it first writes a fixed lockout pattern to the bottom of the controller's memory. This pattern shuts off the controller's serial debug path. The block then reads one word back and compares it with a handshake constant. If the word is wrong, it idles for a fixed delay and repeats the lockout.

Once the handshake matches, the block moves the HPI address pointer to the load area. Each decrypted boot word that arrives on a valid/ready input is forwarded to the HPI as a write, and is also folded into a CRC. After the configured number of words, a sticky boot flag is cleared. Only power-on reset can set that flag again. If the CRC residue is zero at that point, a one-cycle interrupt tells the controller to start.

Memory access for the main CPU stays off until the booted controller pulses a status strobe. A CRC failure locks the block in an error state with no interrupt and memory access off. A later warm reset leaves it locked.

Top module: `hpi_boot_seq`

## Requirements
- R1: While power-on reset is held, boot_flag is 1 and in_ready, hpi_wr, hpi_rd, boot_irq, boot_fail and mem_enable are 0.
- R2: After power-on reset releases, the first HPI transactions are a pointer write (hpi_addr_sel=1) of 0x0000, followed by data writes (hpi_addr_sel=0) of 0xCF00, 0xCF00, 0x2000, 0x2000, 0x0000, 0x0000 in that order.
- R3: The cycle after the last lockout write holds a single hpi_rd strobe. hpi_rdata is sampled in that cycle.
- R4: If the read word differs from the HANDSHAKE parameter, no HPI activity follows for RETRY_WAIT cycles. The R2 pattern then restarts, so the pointer write comes RETRY_WAIT+1 cycles after the read strobe.
- R5: If the read word equals HANDSHAKE, the next transaction is a pointer write of 0x2000. in_ready is then 1, and every accepted in_word is issued as an HPI data write with that value in the same cycle.
- R6: After exactly BOOT_WORDS accepted words, boot_flag goes to 0 and in_ready stays 0. Further offered words are not accepted.
- R7: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. Each 16-bit word is shifted in MSB first, with no final XOR. If the residue over all boot words is 0, boot_irq pulses high for exactly one cycle, once.
- R8: A nonzero residue gives no interrupt and sets boot_fail to 1.
- R9: mem_enable stays 0 until a status_set strobe arrives after a successful boot. Strobes that arrive before the boot ends, or after a failure, are ignored.
- R10: A warm reset (rst_n only) with boot_flag already 0 produces no HPI transaction and no interrupt. It clears mem_enable, which a new status_set re-enables only if the boot succeeded. A failed boot stays failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sets the boot flag |
| rst_n | input | 1 | Warm reset of the sequencer, active low |
| in_word | input | 16 | Decrypted boot word |
| in_valid | input | 1 | in_word is valid |
| in_ready | output | 1 | Sequencer accepts a boot word this cycle |
| hpi_wr | output | 1 | Single-cycle HPI write strobe |
| hpi_addr_sel | output | 1 | 1: write goes to the address pointer, 0: data write |
| hpi_wdata | output | 16 | HPI write value |
| hpi_rd | output | 1 | Single-cycle HPI read strobe |
| hpi_rdata | input | 16 | HPI read value, sampled while hpi_rd is high |
| status_set | input | 1 | Status strobe from the booted controller |
| boot_irq | output | 1 | One-cycle start interrupt to the controller |
| boot_flag | output | 1 | Sticky flag: boot still pending since power-on |
| boot_fail | output | 1 | Boot finished with a bad CRC residue |
| mem_enable | output | 1 | Main CPU memory access allowed |

## Verification
The hardest situation to reach is a run of handshake misses followed by a hit. The retry timing can only be seen as the gap between a read strobe and the next pointer write. The bench therefore makes the read-back value depend on how many read strobes it has already seen, and sweeps zero to two misses against three valid-gap patterns. It measures every gap from the recorded transaction cycles. The bad-residue lock and the warm-reset behaviour need a second power-on run, so the bench builds the final boot word as the CRC of the others and flips one bit of it for the failing case.

// File: rtl/hpi_boot_pkg.sv
package hpi_boot_pkg;
    localparam int HPI_W    = 16;
    localparam int LOCK_LEN = 6;
    localparam logic [HPI_W-1:0] LOCK_BASE   = 16'h0000;
    localparam logic [HPI_W-1:0] STREAM_BASE = 16'h2000;
    localparam logic [HPI_W-1:0] CRC_INIT    = 16'hFFFF;
    localparam logic [HPI_W-1:0] CRC_POLY    = 16'h1021;

    typedef enum logic [3:0] {
        S_START, S_LOCK_ADDR, S_LOCK_DATA, S_POLL, S_WAIT,
        S_LOAD_ADDR, S_STREAM, S_CHECK, S_RUN, S_FAIL
    } boot_state_e;

    // Lockout pattern that silences the controller's debug path
    function automatic logic [HPI_W-1:0] lock_word(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: lock_word = 16'hCF00;
            3'd2, 3'd3: lock_word = 16'h2000;
            default:    lock_word = 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/hpi_crc16_step.sv
module hpi_crc16_step
    import hpi_boot_pkg::*;
(
    input  logic [HPI_W-1:0] crc_in,
    input  logic [HPI_W-1:0] word,
    output logic [HPI_W-1:0] crc_out
);
    always_comb begin
        logic [HPI_W-1:0] acc;
        acc = crc_in;
        for (int b = HPI_W - 1; b >= 0; b--) begin
            if (acc[HPI_W-1] ^ word[b])
                acc = {acc[HPI_W-2:0], 1'b0} ^ CRC_POLY;
            else
                acc = {acc[HPI_W-2:0], 1'b0};
        end
        crc_out = acc;
    end
endmodule

// File: rtl/hpi_boot_latch.sv
module hpi_boot_latch (
    input  logic clk,
    input  logic por_n,
    input  logic clr_flag,
    input  logic set_fail,
    output logic flag,
    output logic fail
);
    typedef struct packed {
        logic flag;
        logic fail;
    } latch_t;

    latch_t q, d;

    always_comb begin
        d = q;
        if (clr_flag) d.flag = 1'b0;
        if (set_fail) d.fail = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '{flag: 1'b1, fail: 1'b0};
        else        q <= d;
    end

    assign flag = q.flag;
    assign fail = q.fail;

    // Only power-on may re-arm the boot flag
    p_flag_no_rearm_r10: assert property (@(posedge clk) disable iff (!por_n)
        !$rose(flag));
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
        !$fell(fail));
endmodule

// File: rtl/hpi_boot_seq.sv
module hpi_boot_seq
    import hpi_boot_pkg::*;
#(
    parameter logic [15:0] HANDSHAKE  = 16'hC3A5,
    parameter int          BOOT_WORDS = 2048,
    parameter int          RETRY_WAIT = 4096
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic [15:0] in_word,
    input  logic        in_valid,
    output logic        in_ready,
    output logic        hpi_wr,
    output logic        hpi_addr_sel,
    output logic [15:0] hpi_wdata,
    output logic        hpi_rd,
    input  logic [15:0] hpi_rdata,
    input  logic        status_set,
    output logic        boot_irq,
    output logic        boot_flag,
    output logic        boot_fail,
    output logic        mem_enable
);
    localparam int SPAN  = (RETRY_WAIT > BOOT_WORDS) ? RETRY_WAIT : BOOT_WORDS;
    localparam int CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_LEN - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(RETRY_WAIT - 1);
    localparam logic [CNT_W-1:0] WORDS_LAST = CNT_W'(BOOT_WORDS - 1);

    typedef struct packed {
        boot_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [HPI_W-1:0] crc;
        logic             mem_en;
    } seq_t;

    seq_t q, d;
    logic [HPI_W-1:0] crc_next;
    logic             clr_flag, set_fail;
    logic             flag, fail;

    hpi_crc16_step u_crc (
        .crc_in  (q.crc),
        .word    (in_word),
        .crc_out (crc_next)
    );

    hpi_boot_latch u_latch (
        .clk      (clk),
        .por_n    (por_n),
        .clr_flag (clr_flag),
        .set_fail (set_fail),
        .flag     (flag),
        .fail     (fail)
    );

    always_comb begin
        d            = q;
        in_ready     = 1'b0;
        hpi_wr       = 1'b0;
        hpi_addr_sel = 1'b0;
        hpi_wdata    = '0;
        hpi_rd       = 1'b0;
        boot_irq     = 1'b0;
        clr_flag     = 1'b0;
        set_fail     = 1'b0;
        case (q.st)
            S_START: begin
                d.cnt = '0;
                d.crc = CRC_INIT;
                if (fail)      d.st = S_FAIL;
                else if (flag) d.st = S_LOCK_ADDR;
                else           d.st = S_RUN;
            end
            S_LOCK_ADDR: begin
                hpi_wr       = 1'b1;
                hpi_addr_sel = 1'b1;
                hpi_wdata    = LOCK_BASE;
                d.cnt        = '0;
                d.st         = S_LOCK_DATA;
            end
            S_LOCK_DATA: begin
                hpi_wr    = 1'b1;
                hpi_wdata = lock_word(q.cnt[2:0]);
                if (q.cnt == LOCK_LAST) begin
                    d.cnt = '0;
                    d.st  = S_POLL;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_POLL: begin
                hpi_rd = 1'b1;
                d.cnt  = '0;
                d.st   = (hpi_rdata == HANDSHAKE) ? S_LOAD_ADDR : S_WAIT;
            end
            S_WAIT: begin
                if (q.cnt == WAIT_LAST) begin
                    d.cnt = '0;
                    d.st  = S_LOCK_ADDR;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_LOAD_ADDR: begin
                hpi_wr       = 1'b1;
                hpi_addr_sel = 1'b1;
                hpi_wdata    = STREAM_BASE;
                d.cnt        = '0;
                d.crc        = CRC_INIT;
                d.st         = S_STREAM;
            end
            S_STREAM: begin
                in_ready  = 1'b1;
                hpi_wdata = in_word;
                if (in_valid) begin
                    hpi_wr = 1'b1;
                    d.crc  = crc_next;
                    if (q.cnt == WORDS_LAST) d.st = S_CHECK;
                    else                     d.cnt = q.cnt + 1'b1;
                end
            end
            S_CHECK: begin
                clr_flag = 1'b1;
                if (q.crc == '0) begin
                    boot_irq = 1'b1;
                    d.st     = S_RUN;
                end else begin
                    set_fail = 1'b1;
                    d.st     = S_FAIL;
                end
            end
            S_RUN: begin
                if (status_set) d.mem_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_START, cnt: '0, crc: CRC_INIT, mem_en: 1'b0};
        else        q <= d;
    end

    assign boot_flag  = flag;
    assign boot_fail  = fail;
    assign mem_enable = q.mem_en;

    p_stream_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (hpi_wr && !hpi_addr_sel && hpi_wdata == in_word));
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hpi_wr && hpi_rd));
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        boot_irq |=> !boot_irq);
    p_irq_clears_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        boot_irq |=> !boot_flag);
    p_no_irq_on_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_fail |-> !boot_irq);
    p_mem_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_enable) |-> ($past(status_set) && !boot_fail && !boot_flag));
    p_ready_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> boot_flag);
endmodule

// File: tb/hpi_boot_seq_bench.sv
`timescale 1ns/1ps
module hpi_boot_seq_bench;
    localparam logic [15:0] HS = 16'h5AC3;
    localparam int N  = 16;
    localparam int RW = 32;
    localparam int MAXEV = 128;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, hpi_wr, hpi_addr_sel, hpi_rd;
    logic [15:0] hpi_wdata, hpi_rdata;
    logic        status_set = 1'b0;
    logic        boot_irq, boot_flag, boot_fail, mem_enable;

    int errs = 0, checks = 0, cyc = 0;
    int ev_n = 0, rd_n = 0, irq_n = 0, feed_idx = 0, phase = 0;
    int bad_polls = 0, gap = 0;
    bit feed_en = 1'b0;
    logic        ev_sel [MAXEV];
    logic [15:0] ev_dat [MAXEV];
    int          ev_cyc [MAXEV];
    int          rd_cyc [MAXEV];
    logic [15:0] words  [N+2];
    logic [15:0] lock_pat [6] = '{16'hCF00, 16'hCF00, 16'h2000, 16'h2000, 16'h0000, 16'h0000};

    hpi_boot_seq #(.HANDSHAKE(HS), .BOOT_WORDS(N), .RETRY_WAIT(RW)) u_hpi_boot_seq (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .hpi_wr(hpi_wr), .hpi_addr_sel(hpi_addr_sel),
        .hpi_wdata(hpi_wdata), .hpi_rd(hpi_rd), .hpi_rdata(hpi_rdata),
        .status_set(status_set), .boot_irq(boot_irq), .boot_flag(boot_flag),
        .boot_fail(boot_fail), .mem_enable(mem_enable)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // read-back turns correct after bad_polls misses
    assign hpi_rdata = (rd_n > bad_polls) ? HS : (HS ^ 16'h0101);

    always @(negedge clk) begin
        if (hpi_wr && ev_n < MAXEV) begin
            ev_sel[ev_n] = hpi_addr_sel;
            ev_dat[ev_n] = hpi_wdata;
            ev_cyc[ev_n] = cyc;
            ev_n++;
        end
        if (hpi_rd && rd_n < MAXEV) begin
            rd_cyc[rd_n] = cyc;
            rd_n++;
        end
        if (boot_irq) irq_n++;
        if (in_valid && in_ready) feed_idx++;
    end

    always @(posedge clk) begin
        #0.5;
        in_valid = feed_en && (feed_idx < N + 2) && (phase % (gap + 1) == 0);
        in_word  = (feed_idx < N + 2) ? words[feed_idx] : 16'h0;
        phase++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [15:0] w);
        logic [15:0] r = c;
        for (int b = 15; b >= 0; b--) begin
            logic top = r[15] ^ w[b];
            r = {r[14:0], 1'b0};
            if (top) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #0.5;
    endtask

    task automatic pulse_status();
        @(posedge clk); #0.5 status_set = 1'b1;
        @(posedge clk); #0.5 status_set = 1'b0;
        cycles(2);
    endtask

    task automatic clear_log();
        ev_n = 0; rd_n = 0; irq_n = 0;
    endtask

    task automatic run_boot(input int bp, input int gp, input bit good, input int seed);
        logic [15:0] c = 16'hFFFF;
        int base;
        for (int i = 0; i < N - 1; i++) begin
            words[i] = 16'(i * 16'h1357 + seed * 16'h0F1D + 16'h00A5);
            c = crc_upd(c, words[i]);
        end
        words[N-1] = good ? c : (c ^ 16'h0001);
        words[N]   = 16'hDEAD;
        words[N+1] = 16'hBEEF;
        bad_polls = bp; gap = gp;
        feed_en = 1'b0; feed_idx = 0; phase = 0;
        @(posedge clk); #0.5 por_n = 1'b0; rst_n = 1'b0;
        cycles(3);
        // R1 reset state
        chk(boot_flag == 1'b1, "R1 flag", boot_flag, 1);
        chk({in_ready, hpi_wr, hpi_rd, boot_irq, boot_fail, mem_enable} == 6'b0,
            "R1 idle outputs", {in_ready, hpi_wr, hpi_rd, boot_irq, boot_fail, mem_enable}, 0);
        clear_log();
        feed_en = 1'b1;
        por_n = 1'b1; rst_n = 1'b1;
        cycles(4);
        pulse_status(); // early strobe must be ignored (R9)
        for (int t = 0; t < 4000 && boot_flag; t++) cycles(1);
        cycles(6);
        chk(ev_n == (bp + 1) * 7 + 1 + N, "R2 transaction count", ev_n, (bp + 1) * 7 + 1 + N);
        chk(rd_n == bp + 1, "R3 read count", rd_n, bp + 1);
        for (int k = 0; k <= bp; k++) begin
            base = k * 7;
            chk(ev_sel[base] == 1'b1 && ev_dat[base] == 16'h0000, "R2 pointer 0", ev_dat[base], 0);
            for (int j = 0; j < 6; j++)
                chk(ev_sel[base+1+j] == 1'b0 && ev_dat[base+1+j] == lock_pat[j],
                    "R2 lock word", ev_dat[base+1+j], lock_pat[j]);
            chk(rd_cyc[k] == ev_cyc[base+6] + 1, "R3 read follows lockout",
                rd_cyc[k] - ev_cyc[base+6], 1);
            if (k < bp)
                chk(ev_cyc[base+7] - rd_cyc[k] == RW + 1, "R4 retry gap",
                    ev_cyc[base+7] - rd_cyc[k], RW + 1);
        end
        base = (bp + 1) * 7;
        chk(ev_sel[base] == 1'b1 && ev_dat[base] == 16'h2000, "R5 load pointer", ev_dat[base], 16'h2000);
        for (int j = 0; j < N; j++)
            chk(ev_sel[base+1+j] == 1'b0 && ev_dat[base+1+j] == words[j], "R5 streamed word",
                ev_dat[base+1+j], words[j]);
        chk(feed_idx == N && in_ready == 1'b0, "R6 no extra accept", feed_idx, N);
        chk(boot_flag == 1'b0, "R6 flag cleared", boot_flag, 0);
        chk(irq_n == (good ? 1 : 0), good ? "R7 irq once" : "R8 no irq", irq_n, good ? 1 : 0);
        chk(boot_fail == !good, "R8 fail flag", boot_fail, !good);
        chk(mem_enable == 1'b0, "R9 early strobe ignored", mem_enable, 0);
        pulse_status();
        chk(mem_enable == good, "R9 enable after status", mem_enable, good);
        feed_en = 1'b0;
        // R10 warm reset
        @(posedge clk); #0.5 rst_n = 1'b0;
        cycles(3);
        clear_log();
        rst_n = 1'b1;
        cycles(RW * 2);
        chk(ev_n == 0 && rd_n == 0, "R10 no HPI activity", ev_n + rd_n, 0);
        chk(irq_n == 0 && boot_flag == 1'b0, "R10 no irq, flag clear", irq_n, 0);
        chk(mem_enable == 1'b0, "R10 mem cleared", mem_enable, 0);
        pulse_status();
        chk(mem_enable == good, "R10 re-enable", mem_enable, good);
        chk(boot_fail == !good, "R10 fail kept", boot_fail, !good);
    endtask

    initial begin
        for (int gp = 0; gp < 3; gp++)
            for (int bp = 0; bp < 3; bp++)
                run_boot(bp, gp, 1'b1, gp * 3 + bp);
        run_boot(1, 1, 1'b0, 11);
        run_boot(0, 2, 1'b0, 12);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule